// File: doc/BRIEF.md
# DMA Burst and Descriptor Sequencer

This block sits inside a network controller's DMA engine. It accepts a buffer transfer made of a byte start address and a length counted in 32-bit longwords. It splits that transfer into bus bursts and issues them one at a time. Each burst carries an address and a beat count. The block holds the burst until the bus side reports completion. The length of each burst is capped by a programmable burst-length setting. A burst also never crosses an optional cache-line boundary, so an unaligned fragment is first brought up to the boundary and later bursts then run aligned.

Two combinational helpers share the same configuration. The first is a byte-lane swapper. It reverses the bytes of each longword of buffer data when big-endian mode is on, and it always passes descriptor words unchanged. The second is a descriptor stepper. It computes the next ring entry address from the current one, the fixed descriptor size and a programmable gap in longwords.

Transfers enter on a valid/ready handshake. `xfer_ready` is high only while the sequencer is idle, so the upstream source holds `xfer_valid` and its payload until a transfer is accepted. A burst request has no ready signal. `req_valid` and its fields stay fixed until the bus side pulses `req_done` for one cycle. Configuration pins are plain levels. A synchronous `soft_rst` abandons any transfer in progress, while the configuration is left as it is.

Top module: `dma_burst_seq`

## Requirements
- R1: After `rst_n` is deasserted, `xfer_ready` is 1, `req_valid` is 0 and `xfer_done` is 0.
- R2: Each burst's `req_beats` equals the smallest of three values: the longwords still to move, the burst limit, and the longwords left before the next alignment boundary. It is never zero.
- R3: `cfg_burst_len` = 0 gives no burst limit. The values 1, 2, 4, 8, 16 and 32 limit each burst to that many longwords.
- R4: Any other nonzero `cfg_burst_len` value acts as a limit of 32 longwords.
- R5: `cfg_cache_align` selects the boundary: 0 gives no boundary, 1 gives 8 longwords, 2 gives 16 longwords and 3 gives 32 longwords. A burst never crosses the selected boundary, where the longword index is `address[ADDR_W-1:2]`.
- R6: `req_valid`, `req_addr` and `req_beats` stay unchanged until `req_done`. The first burst starts at `xfer_addr`. Each following burst starts at the previous address plus 4 × the previous `req_beats`.
- R7: `xfer_done` is high for exactly one cycle, the cycle after the edge that samples the final `req_done`. A zero-length transfer raises `xfer_done` in the cycle after it is accepted, and it issues no burst.
- R8: `xfer_ready` is 0 from the moment a transfer is accepted until it completes, so a new transfer waits.
- R9: With `cfg_big_endian` = 1 and `dat_is_desc` = 0, `dat_out` byte i equals `dat_in` byte (3−i). For example, 0x11223344 becomes 0x44332211.
- R10: `dat_out` equals `dat_in` whenever `dat_is_desc` = 1 or `cfg_big_endian` = 0.
- R11: `desc_next` = `desc_cur` + 16 + 4 × `cfg_desc_skip`.
- R12: Asserting `soft_rst` for one cycle gives `req_valid` = 0 and `xfer_ready` = 1 in the following cycle. A later transfer then runs correctly under the unchanged configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous sequencer reset; configuration unaffected |
| cfg_burst_len | input | 6 | Burst limit in longwords (0 = unlimited) |
| cfg_cache_align | input | 2 | Boundary select |
| cfg_desc_skip | input | 5 | Longwords between descriptors |
| cfg_big_endian | input | 1 | Byte-swap buffer data |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_ready | output | 1 | Sequencer can accept a transfer |
| xfer_addr | input | ADDR_W (32) | Transfer start byte address, longword aligned |
| xfer_len | input | LEN_W (16) | Transfer length in longwords |
| req_valid | output | 1 | Burst request pending |
| req_addr | output | ADDR_W (32) | Burst start byte address |
| req_beats | output | LEN_W (16) | Burst length in longwords |
| req_done | input | 1 | One-cycle burst completion pulse |
| xfer_done | output | 1 | One-cycle transfer completion pulse |
| dat_in | input | DATA_W (32) | Data longword to lane-swap |
| dat_is_desc | input | 1 | Longword belongs to a descriptor |
| dat_out | output | DATA_W (32) | Lane-swapped longword |
| desc_cur | input | ADDR_W (32) | Current descriptor address |
| desc_next | output | ADDR_W (32) | Next descriptor address |

## Verification
The properties assume several things about the inputs. `req_done` only pulses while `req_valid` is high. The burst and alignment settings stay constant for the whole life of a transfer. Transfer addresses are longword aligned. The stimulus changes configuration only while the sequencer is idle, and it raises `req_done` only after it has seen a pending request. It also draws every start address from multiples of four.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PLAN = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  localparam int MAX_BURST = 32;
  localparam int DESC_BYTES = 16;
endpackage

// File: rtl/dma_burst_calc.sv
module dma_burst_calc #(
  parameter int LEN_W = 16,
  parameter int BL_W = 6,
  parameter int MAX_BURST = 32
) (
  input  logic [4:0]       word_ofs,
  input  logic [LEN_W-1:0] remain,
  input  logic [BL_W-1:0]  burst_len,
  input  logic [1:0]       cache_sel,
  output logic [LEN_W-1:0] beats
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BURST);

  logic             legal;
  logic             has_lim;
  logic [LEN_W-1:0] lim;
  logic             has_room;
  logic [LEN_W-1:0] room;
  logic [LEN_W-1:0] m1;

  always_comb begin
    legal   = ((burst_len & (burst_len - 1'b1)) == '0) &&
              (LEN_W'(burst_len) <= CAP);
    has_lim = (burst_len != '0);
    lim     = legal ? LEN_W'(burst_len) : CAP;
  end

  always_comb begin
    has_room = 1'b1;
    unique case (cache_sel)
      2'd1:    room = LEN_W'(8)  - LEN_W'(word_ofs[2:0]);
      2'd2:    room = LEN_W'(16) - LEN_W'(word_ofs[3:0]);
      2'd3:    room = LEN_W'(32) - LEN_W'(word_ofs[4:0]);
      default: begin
        room     = '0;
        has_room = 1'b0;
      end
    endcase
  end

  always_comb begin
    m1    = (has_lim && lim < remain) ? lim : remain;
    beats = (has_room && room < m1) ? room : m1;
  end
endmodule

// File: rtl/dma_lane_swap.sv
module dma_lane_swap #(
  parameter int DATA_W = 32
) (
  input  logic              swap_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int BYTES = DATA_W / 8;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign dout[8*i +: 8] = swap_en ? din[8*(BYTES-1-i) +: 8] : din[8*i +: 8];
  end
endmodule

// File: rtl/dma_desc_step.sv
module dma_desc_step #(
  parameter int ADDR_W = 32,
  parameter int SKIP_W = 5,
  parameter int DESC_BYTES = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [SKIP_W-1:0] skip,
  output logic [ADDR_W-1:0] nxt
);
  localparam int PAD = ADDR_W - SKIP_W - 2;

  assign nxt = cur + ADDR_W'(DESC_BYTES) + {{PAD{1'b0}}, skip, 2'b00};
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32,
  parameter int BL_W   = 6,
  parameter int SKIP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [BL_W-1:0]   cfg_burst_len,
  input  logic [1:0]        cfg_cache_align,
  input  logic [SKIP_W-1:0] cfg_desc_skip,
  input  logic              cfg_big_endian,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_beats,
  input  logic              req_done,
  output logic              xfer_done,
  input  logic [DATA_W-1:0] dat_in,
  input  logic              dat_is_desc,
  output logic [DATA_W-1:0] dat_out,
  input  logic [ADDR_W-1:0] desc_cur,
  output logic [ADDR_W-1:0] desc_next
);
  localparam int PAD = ADDR_W - LEN_W - 2;

  seq_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  beats_c;
  logic              accept;

  dma_burst_calc #(.LEN_W(LEN_W), .BL_W(BL_W), .MAX_BURST(MAX_BURST)) u_calc (
    .word_ofs (cur_addr[6:2]),
    .remain   (remain),
    .burst_len(cfg_burst_len),
    .cache_sel(cfg_cache_align),
    .beats    (beats_c)
  );

  dma_lane_swap #(.DATA_W(DATA_W)) u_swap (
    .swap_en(cfg_big_endian && !dat_is_desc),
    .din    (dat_in),
    .dout   (dat_out)
  );

  dma_desc_step #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W), .DESC_BYTES(DESC_BYTES)) u_step (
    .cur (desc_cur),
    .skip(cfg_desc_skip),
    .nxt (desc_next)
  );

  assign xfer_ready = (state == SEQ_IDLE);
  assign req_valid  = (state == SEQ_WAIT);
  assign accept     = xfer_valid && xfer_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      cur_addr  <= '0;
      remain    <= '0;
      req_addr  <= '0;
      req_beats <= '0;
      xfer_done <= 1'b0;
    end else if (soft_rst) begin
      state     <= SEQ_IDLE;
      remain    <= '0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            cur_addr <= xfer_addr;
            remain   <= xfer_len;
            if (xfer_len == '0) begin
              xfer_done <= 1'b1;
            end else begin
              state <= SEQ_PLAN;
            end
          end
        end
        SEQ_PLAN: begin
          req_addr  <= cur_addr;
          req_beats <= beats_c;
          state     <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (req_done) begin
            cur_addr <= cur_addr + {{PAD{1'b0}}, req_beats, 2'b00};
            remain   <= remain - req_beats;
            if (remain == req_beats) begin
              state     <= SEQ_IDLE;
              xfer_done <= 1'b1;
            end else begin
              state <= SEQ_PLAN;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32,
  parameter int BL_W   = 6,
  parameter int SKIP_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [BL_W-1:0]   cfg_burst_len,
  input logic [1:0]        cfg_cache_align,
  input logic              cfg_big_endian,
  input logic              xfer_ready,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_beats,
  input logic              req_done,
  input logic              xfer_done,
  input logic [DATA_W-1:0] dat_in,
  input logic              dat_is_desc,
  input logic [DATA_W-1:0] dat_out
);
  logic        bl_pow2;
  logic [6:0]  span;
  logic [6:0]  used;

  always_comb begin
    bl_pow2 = (cfg_burst_len == 6'd1) || (cfg_burst_len == 6'd2) ||
              (cfg_burst_len == 6'd4) || (cfg_burst_len == 6'd8) ||
              (cfg_burst_len == 6'd16) || (cfg_burst_len == 6'd32);
    case (cfg_cache_align)
      2'd1:    begin span = 7'd8;  used = {4'd0, req_addr[4:2]}; end
      2'd2:    begin span = 7'd16; used = {3'd0, req_addr[5:2]}; end
      2'd3:    begin span = 7'd32; used = {2'd0, req_addr[6:2]}; end
      default: begin span = 7'd0;  used = 7'd0; end
    endcase
  end

  assert_nonzero_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_beats != '0);

  assert_cap_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bl_pow2) |-> req_beats <= LEN_W'(cfg_burst_len));

  assert_cap_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_burst_len != '0 && !bl_pow2) |-> req_beats <= LEN_W'(32));

  assert_no_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_cache_align != 2'd0) |->
      (LEN_W'(used) + req_beats) <= LEN_W'(span));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_done && !soft_rst) |=>
      (req_valid && $stable(req_addr) && $stable(req_beats)));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!req_valid && xfer_ready));

  assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !xfer_ready);

  assert_desc_plain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_is_desc || !cfg_big_endian) |-> dat_out == dat_in);

  assert_soft_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!req_valid && xfer_ready && !xfer_done));
endmodule

bind dma_burst_seq dma_burst_seq_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .BL_W(BL_W), .SKIP_W(SKIP_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .soft_rst       (soft_rst),
  .cfg_burst_len  (cfg_burst_len),
  .cfg_cache_align(cfg_cache_align),
  .cfg_big_endian (cfg_big_endian),
  .xfer_ready     (xfer_ready),
  .req_valid      (req_valid),
  .req_addr       (req_addr),
  .req_beats      (req_beats),
  .req_done       (req_done),
  .xfer_done      (xfer_done),
  .dat_in         (dat_in),
  .dat_is_desc    (dat_is_desc),
  .dat_out        (dat_out)
);

// File: tb/sim_dma_burst_seq.sv
module sim_dma_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [5:0]  cfg_burst_len = '0;
  logic [1:0]  cfg_cache_align = '0;
  logic [4:0]  cfg_desc_skip = '0;
  logic        cfg_big_endian = 1'b0;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready;
  logic [31:0] xfer_addr = '0;
  logic [15:0] xfer_len = '0;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [15:0] req_beats;
  logic        req_done = 1'b0;
  logic        xfer_done;
  logic [31:0] dat_in = '0;
  logic        dat_is_desc = 1'b0;
  logic [31:0] dat_out;
  logic [31:0] desc_cur = '0;
  logic [31:0] desc_next;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dma_burst_seq u0 (.*);

  // Vector fields: [63:32] addr, [31:16] len, [15:10] burst_len, [9:8] align, [7:0] bursts
  localparam logic [63:0] VEC [8] = '{
    {32'h0000_0000, 16'd20, 6'd8,  2'd0, 8'd3},
    {32'h0000_0014, 16'd10, 6'd0,  2'd1, 8'd2},
    {32'h0000_0000, 16'd40, 6'd0,  2'd0, 8'd1},
    {32'h0000_0008, 16'd5,  6'd1,  2'd3, 8'd5},
    {32'h0000_0000, 16'd40, 6'd7,  2'd0, 8'd2},
    {32'h0000_003C, 16'd20, 6'd16, 2'd2, 8'd3},
    {32'h0000_0000, 16'd70, 6'd48, 2'd3, 8'd3},
    {32'h0000_0010, 16'd6,  6'd4,  2'd1, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_beats(input int waddr, input int rem, input int bl, input int ca);
    int lim;
    int m;
    int b;
    lim = 1 << 30;
    if (bl == 1 || bl == 2 || bl == 4 || bl == 8 || bl == 16 || bl == 32) lim = bl;
    else if (bl != 0) lim = 32;
    m = (rem < lim) ? rem : lim;
    if (ca != 0) begin
      b = 8 << (ca - 1);
      if (b - (waddr % b) < m) m = b - (waddr % b);
    end
    return m;
  endfunction

  task automatic run_xfer(input logic [31:0] a, input int len, input int bl, input int ca,
                          output int nb);
    int addr;
    int rem;
    int exp_b;
    nb = 0;
    @(negedge clk);
    cfg_burst_len = 6'(bl);
    cfg_cache_align = 2'(ca);
    xfer_addr = a;
    xfer_len = 16'(len);
    xfer_valid = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0;
    addr = int'(a);
    rem = len;
    while (rem > 0) begin
      for (int w = 0; w < 10 && !req_valid; w++) @(negedge clk);
      exp_b = model_beats(addr / 4, rem, bl, ca);
      chk(req_valid === 1'b1, "R6 req_valid", req_valid, 1);
      chk(req_addr == 32'(addr), "R6 req_addr", req_addr, addr);
      chk(req_beats == 16'(exp_b), "R2 req_beats", req_beats, exp_b);
      chk(xfer_ready == 1'b0, "R8 busy", xfer_ready, 0);
      @(negedge clk);
      chk(req_valid && req_beats == 16'(exp_b), "R6 held", req_beats, exp_b);
      req_done = 1'b1;
      @(negedge clk);
      req_done = 1'b0;
      addr += 4 * exp_b;
      rem -= exp_b;
      nb++;
      chk(xfer_done == (rem == 0), "R7 done timing", xfer_done, rem == 0);
      if (nb > 100) rem = 0;
    end
    @(negedge clk);
    chk(xfer_done == 1'b0, "R7 single pulse", xfer_done, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    chk(xfer_ready == 1 && req_valid == 0 && xfer_done == 0, "R1 reset state",
        {xfer_ready, req_valid, xfer_done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(xfer_ready == 1 && req_valid == 0 && xfer_done == 0, "R1 after release",
        {xfer_ready, req_valid, xfer_done}, 3'b100);

    // Table of transfers: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      run_xfer(VEC[i][63:32], int'(VEC[i][31:16]), int'(VEC[i][15:10]),
               int'(VEC[i][9:8]), nb);
      chk(nb == int'(VEC[i][7:0]), "R2 burst count", nb, VEC[i][7:0]);
    end

    // R4 explicit: illegal limit 7 behaves as 32
    run_xfer(32'h0, 32, 7, 0, nb);
    chk(nb == 1, "R4 illegal as 32", nb, 1);

    // R7 zero length
    @(negedge clk);
    xfer_len = 16'd0;
    xfer_addr = 32'h100;
    xfer_valid = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0;
    chk(xfer_done == 1'b1 && req_valid == 1'b0, "R7 zero length done",
        {xfer_done, req_valid}, 2'b10);
    @(negedge clk);
    chk(xfer_done == 1'b0 && req_valid == 1'b0, "R7 zero length no burst",
        {xfer_done, req_valid}, 2'b00);

    // R12 soft reset mid transfer
    cfg_burst_len = 6'd8;
    cfg_cache_align = 2'd0;
    xfer_addr = 32'h0;
    xfer_len = 16'd20;
    xfer_valid = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0;
    @(negedge clk);
    chk(req_valid == 1'b1, "R12 pending before", req_valid, 1);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(req_valid == 1'b0 && xfer_ready == 1'b1, "R12 idle after soft reset",
        {req_valid, xfer_ready}, 2'b01);
    run_xfer(32'h20, 12, 8, 0, nb);
    chk(nb == 2, "R12 resumes with kept config", nb, 2);

    // R9 R10 lane swap
    dat_in = 32'h1122_3344;
    cfg_big_endian = 1'b1;
    dat_is_desc = 1'b0;
    #1;
    chk(dat_out == 32'h4433_2211, "R9 swap data", dat_out, 32'h4433_2211);
    dat_is_desc = 1'b1;
    #1;
    chk(dat_out == 32'h1122_3344, "R10 descriptor unswapped", dat_out, 32'h1122_3344);
    cfg_big_endian = 1'b0;
    dat_is_desc = 1'b0;
    #1;
    chk(dat_out == 32'h1122_3344, "R10 little endian", dat_out, 32'h1122_3344);

    // R11 descriptor step
    desc_cur = 32'h1000;
    cfg_desc_skip = 5'd0;
    #1;
    chk(desc_next == 32'h1010, "R11 skip 0", desc_next, 32'h1010);
    cfg_desc_skip = 5'd31;
    #1;
    chk(desc_next == 32'h108C, "R11 skip 31", desc_next, 32'h108C);
    cfg_desc_skip = 5'd3;
    #1;
    chk(desc_next == 32'h101C, "R11 skip 3", desc_next, 32'h101C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule